// File: doc/BRIEF.md
# Partial-Width Aliasing Register File

This block is the integer register file of a 64-bit core. It holds sixteen 64-bit registers and has one write port and two read ports. Every port names a register and an operand width of 8, 16, 32 or 64 bits. A high-byte select lets the first four registers be used as an 8-bit operand at bits 15:8. As a result, the narrow views alias onto the full registers and are not separate storage.

A write merges into the old register contents or zero-extends, depending on its width. A 32-bit write clears the upper half of the register. Writes of 8 and 16 bits keep every bit they do not cover. A read returns the selected field at the low end of a 64-bit result, with every bit above it zero.

Each port checks its own request. If a request uses the high-byte select on a register above index 3, or uses it with a width other than 8, the port raises its illegal flag and the request has no effect. Reads are combinational. A read of the register being written in the same cycle sees the merged value that the write will leave behind.

Top module: `alias_regfile`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to zero.
- R2: Register indices are 4 bits (0 to 15). A legal 64-bit write (size code 2'b11) replaces all 64 bits, and a 64-bit read returns them unchanged.
- R3: A legal 32-bit write (size code 2'b10) stores data bits 31:0 and forces register bits 63:32 to zero.
- R4: A legal 16-bit write (size code 2'b01) changes only bits 15:0. A legal low-byte write (size code 2'b00, high select low) changes only bits 7:0.
- R5: For indices 0 to 3, size code 2'b00 with the high select set addresses bits 15:8. A write of this form changes only bits 15:8. A read of this form returns bits 15:8 in result bits 7:0.
- R6: A request that sets the high select with an index above 3, or with a size code other than 2'b00, is illegal. The port's illegal flag is 1. An illegal write changes no register. An illegal read returns zero.
- R7: A read returns the field chosen by its size code in the low bits of the 64-bit result: 8, 16, 32 or 64 bits for codes 2'b00, 2'b01, 2'b10 and 2'b11. All higher result bits are zero.
- R8: A read of the register that a legal, enabled write targets in the same cycle returns the merged value after the write.
- R9: The two read ports decode their own index, size and high select independently of each other.
- R10: The low-byte view works on every index, including 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_idx | input | 4 | Register written |
| wr_size | input | 2 | Write width code |
| wr_hi | input | 1 | Write targets bits 15:8 |
| wr_data | input | 64 | Write data, right-aligned |
| wr_illegal | output | 1 | Enabled write request is illegal |
| rd0_idx | input | 4 | Read port 0 register |
| rd0_size | input | 2 | Read port 0 width code |
| rd0_hi | input | 1 | Read port 0 high-byte select |
| rd0_data | output | 64 | Read port 0 result, zero-extended |
| rd0_illegal | output | 1 | Read port 0 request is illegal |
| rd1_idx | input | 4 | Read port 1 register |
| rd1_size | input | 2 | Read port 1 width code |
| rd1_hi | input | 1 | Read port 1 high-byte select |
| rd1_data | output | 64 | Read port 1 result, zero-extended |
| rd1_illegal | output | 1 | Read port 1 request is illegal |

## Verification
Read results and all three illegal flags are combinational, so they are due in the same cycle as the request. The bench samples them 2 ns after the falling edge at which it drove the inputs, which is before the next rising edge, so a same-cycle write is seen only through the bypass. A write reaches the register contents at the next rising edge. The bench therefore reads the register back in the following cycle, and the bound checker compares the register state one edge after each captured write.

// File: rtl/ar_pkg.sv
package ar_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_W = 2'b01,
    SZ_D = 2'b10,
    SZ_Q = 2'b11
  } opsz_e;
endpackage

// File: rtl/ar_legal.sv
// Decides whether an index/size/high-select combination is a legal operand.
module ar_legal #(
  parameter int IDXW    = 4,
  parameter int HI_REGS = 4
) (
  input  logic [IDXW-1:0] idx,
  input  logic [1:0]      size,
  input  logic            hi,
  output logic            ok
);
  import ar_pkg::*;
  always_comb begin
    ok = 1'b1;
    if (hi) begin
      if (int'(idx) >= HI_REGS) ok = 1'b0;
      if (opsz_e'(size) != SZ_B) ok = 1'b0;
    end
  end
endmodule

// File: rtl/ar_merge.sv
// Combines incoming write data with the old register value per width rules.
module ar_merge #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] data,
  input  logic [1:0]      size,
  input  logic            hi,
  output logic [XLEN-1:0] merged
);
  import ar_pkg::*;
  localparam int BW = XLEN / 8;
  localparam int WW = XLEN / 4;
  localparam int DW = XLEN / 2;

  always_comb begin
    merged = old_val;
    case (opsz_e'(size))
      SZ_B: begin
        if (hi) merged[2*BW-1:BW] = data[BW-1:0];
        else    merged[BW-1:0]    = data[BW-1:0];
      end
      SZ_W:    merged[WW-1:0] = data[WW-1:0];
      SZ_D:    merged = {{(XLEN-DW){1'b0}}, data[DW-1:0]};
      default: merged = data;
    endcase
  end
endmodule

// File: rtl/ar_extract.sv
// Selects the read field and zero-extends it to full width.
module ar_extract #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] value,
  input  logic [1:0]      size,
  input  logic            hi,
  input  logic            ok,
  output logic [XLEN-1:0] field
);
  import ar_pkg::*;
  localparam int BW = XLEN / 8;
  localparam int WW = XLEN / 4;
  localparam int DW = XLEN / 2;

  always_comb begin
    field = '0;
    if (ok) begin
      case (opsz_e'(size))
        SZ_B: begin
          if (hi) field[BW-1:0] = value[2*BW-1:BW];
          else    field[BW-1:0] = value[BW-1:0];
        end
        SZ_W:    field[WW-1:0] = value[WW-1:0];
        SZ_D:    field[DW-1:0] = value[DW-1:0];
        default: field = value;
      endcase
    end
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
  parameter int XLEN    = 64,
  parameter int NREG    = 16,
  parameter int HI_REGS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [1:0]               wr_size,
  input  logic                     wr_hi,
  input  logic [XLEN-1:0]          wr_data,
  output logic                     wr_illegal,
  input  logic [$clog2(NREG)-1:0]  rd0_idx,
  input  logic [1:0]               rd0_size,
  input  logic                     rd0_hi,
  output logic [XLEN-1:0]          rd0_data,
  output logic                     rd0_illegal,
  input  logic [$clog2(NREG)-1:0]  rd1_idx,
  input  logic [1:0]               rd1_size,
  input  logic                     rd1_hi,
  output logic [XLEN-1:0]          rd1_data,
  output logic                     rd1_illegal
);
  localparam int IDXW = $clog2(NREG);
  localparam int NRD  = 2;

  logic [XLEN-1:0]      regs_q [NREG];
  logic [NREG*XLEN-1:0] regs_flat;
  logic                 wr_legal;
  logic                 wr_ok;
  logic [XLEN-1:0]      wr_merged;

  // write path
  ar_legal #(.IDXW(IDXW), .HI_REGS(HI_REGS)) u_wr_legal (
    .idx(wr_idx), .size(wr_size), .hi(wr_hi), .ok(wr_legal)
  );

  ar_merge #(.XLEN(XLEN)) u_merge (
    .old_val(regs_q[wr_idx]), .data(wr_data), .size(wr_size),
    .hi(wr_hi), .merged(wr_merged)
  );

  assign wr_ok      = wr_en & wr_legal;
  assign wr_illegal = wr_en & ~wr_legal;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                            regs_q[r] <= '0;
      else if (wr_ok && int'(wr_idx) == r) regs_q[r] <= wr_merged;
    end
    assign regs_flat[r*XLEN +: XLEN] = regs_q[r];
  end

  // read ports
  logic [IDXW-1:0] rp_idx  [NRD];
  logic [1:0]      rp_size [NRD];
  logic            rp_hi   [NRD];
  logic [XLEN-1:0] rp_data [NRD];
  logic            rp_ok   [NRD];

  assign rp_idx[0] = rd0_idx;  assign rp_size[0] = rd0_size;  assign rp_hi[0] = rd0_hi;
  assign rp_idx[1] = rd1_idx;  assign rp_size[1] = rd1_size;  assign rp_hi[1] = rd1_hi;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [XLEN-1:0] src;
    ar_legal #(.IDXW(IDXW), .HI_REGS(HI_REGS)) u_rd_legal (
      .idx(rp_idx[p]), .size(rp_size[p]), .hi(rp_hi[p]), .ok(rp_ok[p])
    );
    // write-first bypass
    assign src = (wr_ok && wr_idx == rp_idx[p]) ? wr_merged : regs_q[rp_idx[p]];
    ar_extract #(.XLEN(XLEN)) u_ext (
      .value(src), .size(rp_size[p]), .hi(rp_hi[p]), .ok(rp_ok[p]),
      .field(rp_data[p])
    );
  end

  assign rd0_data    = rp_data[0];
  assign rd1_data    = rp_data[1];
  assign rd0_illegal = ~rp_ok[0];
  assign rd1_illegal = ~rp_ok[1];
endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk #(
  parameter int XLEN = 64,
  parameter int NREG = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [$clog2(NREG)-1:0] wr_idx,
  input logic [1:0]              wr_size,
  input logic                    wr_hi,
  input logic [XLEN-1:0]         wr_data,
  input logic                    wr_illegal,
  input logic [$clog2(NREG)-1:0] rd0_idx,
  input logic [1:0]              rd0_size,
  input logic                    rd0_hi,
  input logic [XLEN-1:0]         rd0_data,
  input logic                    rd0_illegal,
  input logic [NREG*XLEN-1:0]    regs_flat
);
  localparam int IDXW = $clog2(NREG);

  logic                 c_v, c_bad;
  logic [IDXW-1:0]      c_idx;
  logic [1:0]           c_sz;
  logic                 c_hi;
  logic [XLEN-1:0]      c_d, c_old;
  logic [NREG*XLEN-1:0] c_all;
  logic [XLEN-1:0]      cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_v   <= 1'b0;
      c_bad <= 1'b0;
    end else begin
      c_v   <= wr_en & ~wr_illegal;
      c_bad <= wr_illegal;
    end
    c_idx <= wr_idx;
    c_sz  <= wr_size;
    c_hi  <= wr_hi;
    c_d   <= wr_data;
    c_old <= regs_flat[int'(wr_idx)*XLEN +: XLEN];
    c_all <= regs_flat;
  end

  assign cur = regs_flat[int'(c_idx)*XLEN +: XLEN];

  AST_WR_DWORD_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (c_v && c_sz == 2'b10) |-> (cur == {{(XLEN/2){1'b0}}, c_d[XLEN/2-1:0]})); // R3
  AST_WR_WORD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (c_v && c_sz == 2'b01) |-> (cur[XLEN-1:16] == c_old[XLEN-1:16] && cur[15:0] == c_d[15:0])); // R4
  AST_WR_BYTE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (c_v && c_sz == 2'b00 && !c_hi) |-> (cur[XLEN-1:8] == c_old[XLEN-1:8] && cur[7:0] == c_d[7:0])); // R4
  AST_WR_HIBYTE: assert property (@(posedge clk) disable iff (rst)
    (c_v && c_hi) |-> (cur[XLEN-1:16] == c_old[XLEN-1:16] && cur[15:8] == c_d[7:0] && cur[7:0] == c_old[7:0])); // R5
  AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    c_bad |-> (regs_flat == c_all)); // R6
  AST_RD_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd0_illegal |-> (rd0_data == '0)); // R6
  AST_RD_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (rd0_size == 2'b00) |-> (rd0_data[XLEN-1:8] == '0)); // R7
  AST_RD_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_illegal && rd0_idx == wr_idx && rd0_size == 2'b11 && !rd0_hi)
      |=> (cur == $past(rd0_data))); // R8
endmodule

bind alias_regfile alias_regfile_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
  .wr_hi(wr_hi), .wr_data(wr_data), .wr_illegal(wr_illegal),
  .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi),
  .rd0_data(rd0_data), .rd0_illegal(rd0_illegal), .regs_flat(regs_flat)
);

// File: tb/alias_regfile_test.sv
`timescale 1ns/1ps
module alias_regfile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [1:0]  wr_size = '0;
  logic        wr_hi = 1'b0;
  logic [63:0] wr_data = '0;
  logic        wr_illegal;
  logic [3:0]  rd0_idx = '0, rd1_idx = '0;
  logic [1:0]  rd0_size = '0, rd1_size = '0;
  logic        rd0_hi = 1'b0, rd1_hi = 1'b0;
  logic [63:0] rd0_data, rd1_data;
  logic        rd0_illegal, rd1_illegal;

  int checks = 0;
  int fails  = 0;
  logic [63:0] model [16];

  always #10 clk = ~clk;

  alias_regfile uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_hi(wr_hi), .wr_data(wr_data), .wr_illegal(wr_illegal),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi),
    .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_hi(rd1_hi),
    .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
  );

  typedef struct packed {
    logic [3:0]  wi;
    logic [1:0]  ws;
    logic        wh;
    logic [63:0] wd;
    logic        wbad;
    logic [3:0]  ri;
    logic [1:0]  rs;
    logic        rh;
    logic [63:0] exp;
    logic [3:0]  req;
  } tv_t;

  localparam int NTV = 11;
  localparam tv_t TBL [NTV] = '{
    '{4'd0,  2'd3, 1'b0, 64'h1122334455667788, 1'b0, 4'd0,  2'd3, 1'b0, 64'h1122334455667788, 4'd2},  // R2
    '{4'd0,  2'd2, 1'b0, 64'hAAAAAAAADEADBEEF, 1'b0, 4'd0,  2'd3, 1'b0, 64'h00000000DEADBEEF, 4'd3},  // R3
    '{4'd0,  2'd1, 1'b0, 64'hFFFFFFFFFFFF1234, 1'b0, 4'd0,  2'd3, 1'b0, 64'h00000000DEAD1234, 4'd4},  // R4
    '{4'd0,  2'd0, 1'b1, 64'hFFFFFFFFFFFFFF77, 1'b0, 4'd0,  2'd3, 1'b0, 64'h00000000DEAD7734, 4'd5},  // R5
    '{4'd0,  2'd0, 1'b0, 64'hFFFFFFFFFFFFFF99, 1'b0, 4'd0,  2'd3, 1'b0, 64'h00000000DEAD7799, 4'd4},  // R4
    '{4'd0,  2'd1, 1'b1, 64'hFFFFFFFFFFFFFFFF, 1'b1, 4'd0,  2'd0, 1'b1, 64'h0000000000000077, 4'd6},  // R6
    '{4'd5,  2'd3, 1'b0, 64'h0123456789ABCDEF, 1'b0, 4'd5,  2'd0, 1'b0, 64'h00000000000000EF, 4'd10}, // R10
    '{4'd5,  2'd0, 1'b0, 64'hFFFFFFFFFFFFFF55, 1'b0, 4'd5,  2'd3, 1'b0, 64'h0123456789ABCD55, 4'd10}, // R10
    '{4'd5,  2'd0, 1'b1, 64'hFFFFFFFFFFFFFFFF, 1'b1, 4'd5,  2'd3, 1'b0, 64'h0123456789ABCD55, 4'd6},  // R6
    '{4'd15, 2'd3, 1'b0, 64'hFEDCBA9876543210, 1'b0, 4'd15, 2'd2, 1'b0, 64'h0000000076543210, 4'd7},  // R7
    '{4'd15, 2'd1, 1'b0, 64'h000000000000BEEF, 1'b0, 4'd15, 2'd1, 1'b0, 64'h000000000000BEEF, 4'd7}   // R7
  };

  function automatic logic ref_ok(logic [3:0] i, logic [1:0] s, logic h);
    return !(h && (i > 4'd3 || s != 2'b00));
  endfunction

  function automatic logic [63:0] ref_merge(logic [63:0] o, logic [63:0] d, logic [1:0] s, logic h);
    case (s)
      2'b00:   return h ? {o[63:16], d[7:0], o[7:0]} : {o[63:8], d[7:0]};
      2'b01:   return {o[63:16], d[15:0]};
      2'b10:   return {32'h0, d[31:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [63:0] ref_read(logic [63:0] v, logic [1:0] s, logic h);
    case (s)
      2'b00:   return h ? {56'h0, v[15:8]} : {56'h0, v[7:0]};
      2'b01:   return {48'h0, v[15:0]};
      2'b10:   return {32'h0, v[31:0]};
      default: return v;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // value a read port should show this cycle, including same-cycle bypass
  function automatic logic [63:0] expect_rd(logic [3:0] i, logic [1:0] s, logic h);
    logic [63:0] v;
    if (!ref_ok(i, s, h)) return 64'h0;
    v = model[i];
    if (wr_en && ref_ok(wr_idx, wr_size, wr_hi) && wr_idx == i)
      v = ref_merge(model[i], wr_data, wr_size, wr_hi);
    return ref_read(v, s, h);
  endfunction

  task automatic commit();
    @(posedge clk);
    if (rst) begin
      for (int k = 0; k < 16; k++) model[k] = '0;
    end else if (wr_en && ref_ok(wr_idx, wr_size, wr_hi)) begin
      model[wr_idx] = ref_merge(model[wr_idx], wr_data, wr_size, wr_hi);
    end
  endtask

  task automatic sweep(string tag);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      rd0_idx = 4'(k);      rd0_size = 2'b11; rd0_hi = 1'b0;
      rd1_idx = 4'(15 - k); rd1_size = 2'b11; rd1_hi = 1'b0;
      #2;
      chk(tag, rd0_data, model[k]);
      chk(tag, rd1_data, model[15 - k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) model[k] = 64'hFFFFFFFFFFFFFFFF;
    rst = 1'b1;
    commit();
    commit();
    @(negedge clk);
    rst = 1'b0;
    sweep("R1 reset clears");

    // table of write-then-read vectors
    for (int t = 0; t < NTV; t++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = TBL[t].wi; wr_size = TBL[t].ws;
      wr_hi = TBL[t].wh; wr_data = TBL[t].wd;
      #2;
      chk($sformatf("R%0d table %0d write flag", TBL[t].req, t), {63'h0, wr_illegal}, {63'h0, TBL[t].wbad});
      commit();
      @(negedge clk);
      wr_en = 1'b0;
      rd0_idx = TBL[t].ri; rd0_size = TBL[t].rs; rd0_hi = TBL[t].rh;
      #2;
      chk($sformatf("R%0d table %0d read", TBL[t].req, t), rd0_data, TBL[t].exp);
    end

    // R8 bypass: 64-bit then 16-bit write to reg 3, read in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd3; wr_size = 2'b11; wr_hi = 1'b0; wr_data = 64'hCAFEF00D12345678;
    rd0_idx = 4'd3; rd0_size = 2'b11; rd0_hi = 1'b0;
    rd1_idx = 4'd3; rd1_size = 2'b00; rd1_hi = 1'b1;
    #2;
    chk("R8 bypass q", rd0_data, 64'hCAFEF00D12345678);
    chk("R8 bypass hi byte", rd1_data, 64'h56);
    commit();
    @(negedge clk);
    wr_size = 2'b01; wr_data = 64'h000000000000ABCD;
    #2;
    chk("R8 bypass merge", rd0_data, 64'hCAFEF00D1234ABCD);
    chk("R8 bypass merge hi", rd1_data, 64'hAB);
    commit();

    // R6 illegal reads on both ports, R9 independent decode
    @(negedge clk);
    wr_en = 1'b0;
    rd0_idx = 4'd3; rd0_size = 2'b01; rd0_hi = 1'b0;
    rd1_idx = 4'd9; rd1_size = 2'b00; rd1_hi = 1'b1;
    #2;
    chk("R6 rd1 illegal flag", {63'h0, rd1_illegal}, 64'h1);
    chk("R6 rd1 illegal data", rd1_data, 64'h0);
    chk("R9 rd0 unaffected", rd0_data, 64'hABCD);
    chk("R9 rd0 flag", {63'h0, rd0_illegal}, 64'h0);
    @(negedge clk);
    rd0_idx = 4'd2; rd0_size = 2'b11; rd0_hi = 1'b1;
    #2;
    chk("R6 rd0 hi with size 64", {63'h0, rd0_illegal}, 64'h1);
    chk("R6 rd0 illegal data", rd0_data, 64'h0);

    // random mixed-size traffic against the model (R3 R4 R5 R8 R9 R10)
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      wr_en   = ($urandom % 4) != 0;
      wr_idx  = 4'($urandom % 16);
      wr_size = 2'($urandom % 4);
      wr_hi   = ($urandom % 4) == 0;
      wr_data = {$urandom, $urandom};
      rd0_idx = (($urandom % 2) == 0) ? wr_idx : 4'($urandom % 16);
      rd0_size = 2'($urandom % 4); rd0_hi = ($urandom % 6) == 0;
      rd1_idx = 4'($urandom % 16);
      rd1_size = 2'($urandom % 4); rd1_hi = ($urandom % 6) == 0;
      #2;
      chk("R8 random rd0", rd0_data, expect_rd(rd0_idx, rd0_size, rd0_hi));
      chk("R9 random rd1", rd1_data, expect_rd(rd1_idx, rd1_size, rd1_hi));
      chk("R6 random wr flag", {63'h0, wr_illegal}, {63'h0, wr_en & ~ref_ok(wr_idx, wr_size, wr_hi)});
      commit();
    end
    @(negedge clk);
    wr_en = 1'b0;
    sweep("R4 final contents");

    // R1 reset after traffic
    @(negedge clk);
    rst = 1'b1;
    commit();
    @(negedge clk);
    rst = 1'b0;
    sweep("R1 reset after traffic");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule